// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block owns the eight 80-bit floating-point data registers of a floating-point unit and handles them as a circular stack that grows downward. A 3-bit pointer names the physical register that is the current top. Each register carries a 2-bit class tag that is worked out when a value is written. The block also keeps the stack-fault part of the unit's 16-bit status word. A register value is packed as sign (bit 79), biased exponent (bits 78:64) and significand (bits 63:0).

Each cycle the surrounding unit may request a push (load), a pop (store) or both at once. The value a pop would hand back is always on `tos_data_o`, and it is taken in the same cycle as the pop. Pointer, tags and flags change on the rising clock edge. A push into a register that is still occupied is an overflow. A pop of an empty top is an underflow. Both set a sticky stack-fault flag and the invalid-operation flag, and condition bit C1 tells the two faults apart. The exception-summary bit is formed from the invalid-operation flag and a mask input that comes from the control word.

Top module: `fpstk_ctrl`

## Requirements
- R1: After a synchronous reset the top pointer is 0, every tag is empty (tag word 16'hFFFF) and every status bit is 0.
- R2: A push alone moves the pointer to top-1 modulo 8, so 0 wraps to 7. The operand is stored in that new top register. Status bits 13:11 always carry the pointer as a plain binary register number.
- R3: `tos_data_o` shows the contents of the top register whenever that register is not empty. A pop alone takes this value, marks the register empty (tag 11) and moves the pointer to top+1 modulo 8.
- R4: A written value is tagged as follows. Exponent 0 with significand 0 gives 01 (zero). An all-ones exponent gives 10 (special). Exponent 0 with a nonzero significand also gives 10. A nonzero exponent with significand bit 63 clear also gives 10. Every other value gives 00 (valid). Register i's tag sits in tag word bits 2i+1:2i.
- R5: A push whose target register (top-1) is not empty is an overflow. It sets status bit 6 (stack fault), bit 0 (invalid) and bit 9 (C1) to 1. The pointer still moves, and the target receives the default NaN 80'hFFFF_C000_0000_0000_0000 with tag 10.
- R6: A pop while the top register is empty is an underflow. It sets status bits 6 and 0 and clears bit 9. `tos_data_o` shows the default NaN for such a register. The pointer still moves up.
- R7: Status bits 6 and 0 stay set until reset. Bit 9 changes only on a fault.
- R8: Status bit 7 is 1 exactly when bit 0 is set and mask input bit 0 is clear. It follows the mask in the same cycle. Bits 15, 14, 10, 8 and 5:1 read 0.
- R9: A push and a pop in the same cycle act as pop-then-push. The old top value is returned, the pointer stays put, and the top register takes the push operand with its class tag. If that register was empty this counts as an underflow (R6 flags). It is never an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| push_i | input | 1 | Push (load) request |
| pop_i | input | 1 | Pop (store) request |
| push_data_i | input | 80 | Operand for a push |
| fpu_mask_i | input | 6 | Exception mask bits from the control word |
| tos_data_o | output | 80 | Value at the current top (default NaN if empty) |
| status_o | output | 16 | Status word |
| tag_word_o | output | 16 | Tag word, two bits per physical register |

## Verification
A push and a pop may arrive in the same cycle. Then one register is both read and rewritten while the pointer must stay where it is, and the underflow test must still look at the register as it was before the write. The bench issues such combined requests, both directed (onto an empty top and onto a loaded top) and mixed into the random stream. A reference model runs the pop before the push and predicts the returned value, the tag, the pointer and the flags. These predictions are compared with the ports in the following cycle.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    localparam int unsigned EXP_W   = 15;
    localparam int unsigned SIG_W   = 64;
    localparam int unsigned FP_W    = 1 + EXP_W + SIG_W;
    localparam int unsigned NREG    = 8;
    localparam int unsigned PTR_W   = $clog2(NREG);
    localparam int unsigned TAG_W   = 2;
    localparam int unsigned TWORD_W = TAG_W * NREG;
    localparam int unsigned STAT_W  = 16;
    localparam int unsigned EXC_W   = 6;

    // status word positions the surrounding unit decodes
    localparam int unsigned ST_IE     = 0;
    localparam int unsigned ST_SF     = 6;
    localparam int unsigned ST_ES     = 7;
    localparam int unsigned ST_C1     = 9;
    localparam int unsigned ST_TOP_LO = 11;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } fpval_t;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [TAG_W-1:0] {
        TAG_VALID   = 2'b00,
        TAG_ZERO    = 2'b01,
        TAG_SPECIAL = 2'b10,
        TAG_EMPTY   = 2'b11
    } tag_e;

    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_REPL = 2'b11
    } op_e;

    typedef struct packed {
        logic over;
        logic under;
    } fault_t;

    localparam fpval_t QNAN_DEFAULT = '{
        sign: 1'b1,
        exp:  {EXP_W{1'b1}},
        sig:  {2'b11, {(SIG_W-2){1'b0}}}
    };

    function automatic tag_e classify_tag(input fpval_t v);
        if (v.exp == {EXP_W{1'b1}})
            return TAG_SPECIAL;
        if (v.exp == '0)
            return (v.sig == '0) ? TAG_ZERO : TAG_SPECIAL;
        if (!v.sig[SIG_W-1])
            return TAG_SPECIAL;
        return TAG_VALID;
    endfunction

    function automatic tag_e tag_at(input logic [TWORD_W-1:0] w, input ptr_t i);
        return tag_e'(w[TAG_W*i +: TAG_W]);
    endfunction

endpackage

// File: rtl/fpstk_seq.sv
module fpstk_seq
    import fpstk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic [TWORD_W-1:0] tag_word_i,
    output ptr_t               top_o,
    output ptr_t               idx_o,
    output logic               wr_en_o,
    output logic               clr_en_o,
    output logic               wr_nan_o,
    output fault_t             fault_o
);

    ptr_t top_q, top_d;
    ptr_t below;
    op_e  op;
    tag_e cur_tag, below_tag;

    assign op        = op_e'({push_i, pop_i});
    assign below     = ptr_t'(top_q - 1'b1);
    assign cur_tag   = tag_at(tag_word_i, top_q);
    assign below_tag = tag_at(tag_word_i, below);

    always_comb begin
        top_d    = top_q;
        idx_o    = top_q;
        wr_en_o  = 1'b0;
        clr_en_o = 1'b0;
        wr_nan_o = 1'b0;
        fault_o  = '0;
        unique case (op)
            OP_PUSH: begin
                idx_o         = below;
                wr_en_o       = 1'b1;
                fault_o.over  = (below_tag != TAG_EMPTY);
                wr_nan_o      = fault_o.over;
                top_d         = below;
            end
            OP_POP: begin
                clr_en_o      = 1'b1;
                fault_o.under = (cur_tag == TAG_EMPTY);
                top_d         = ptr_t'(top_q + 1'b1);
            end
            OP_REPL: begin
                wr_en_o       = 1'b1;
                fault_o.under = (cur_tag == TAG_EMPTY);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) top_q <= '0;
        else     top_q <= top_d;
    end

    assign top_o = top_q;

    // R2: lone push moves the pointer down by one, modulo the register count
    a_r2_push_moves_down: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i) |=> (top_q == ptr_t'($past(top_q) - 1'b1)));

    // R3: lone pop moves the pointer up by one
    a_r3_pop_moves_up: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i) |=> (top_q == ptr_t'($past(top_q) + 1'b1)));

    // R9: combined request leaves the pointer in place
    a_r9_repl_keeps_top: assert property (@(posedge clk) disable iff (rst)
        (pop_i && push_i) |=> $stable(top_q));

    // R9: a combined request never reports overflow
    a_r9_repl_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (pop_i && push_i) |-> !fault_o.over);

endmodule

// File: rtl/fpstk_bank.sv
module fpstk_bank
    import fpstk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic               clr_en_i,
    input  ptr_t               idx_i,
    input  fpval_t             wr_data_i,
    input  tag_e               wr_tag_i,
    input  ptr_t               rd_idx_i,
    output fpval_t             rd_data_o,
    output logic [TWORD_W-1:0] tag_word_o
);

    fpval_t data_q [NREG];
    tag_e   tag_q  [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic hit;
        assign hit = (idx_i == ptr_t'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[i] <= '0;
                tag_q[i]  <= TAG_EMPTY;
            end else if (wr_en_i && hit) begin
                data_q[i] <= wr_data_i;
                tag_q[i]  <= wr_tag_i;
            end else if (clr_en_i && hit) begin
                tag_q[i]  <= TAG_EMPTY;
            end
        end

        assign tag_word_o[TAG_W*i +: TAG_W] = tag_q[i];
    end

    assign rd_data_o = data_q[rd_idx_i];

    // R2: written operand lands in the addressed register
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (data_q[$past(idx_i)] == $past(wr_data_i)));

    // R3: a lone pop leaves the released register empty
    a_r3_pop_empties: assert property (@(posedge clk) disable iff (rst)
        (clr_en_i && !wr_en_i) |=> (tag_q[$past(idx_i)] == TAG_EMPTY));

    // R4: the stored tag is the tag presented with the write
    a_r4_tag_stored: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (tag_q[$past(idx_i)] == $past(wr_tag_i)));

endmodule

// File: rtl/fpstk_flags.sv
module fpstk_flags
    import fpstk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fault_t           fault_i,
    input  logic [EXC_W-1:0] mask_i,
    output logic             ie_o,
    output logic             sf_o,
    output logic             c1_o,
    output logic             es_o
);

    logic             ie_q, sf_q, c1_q;
    logic [EXC_W-1:0] exc_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= 1'b0;
            sf_q <= 1'b0;
            c1_q <= 1'b0;
        end else if (fault_i.over) begin
            ie_q <= 1'b1;
            sf_q <= 1'b1;
            c1_q <= 1'b1;
        end else if (fault_i.under) begin
            ie_q <= 1'b1;
            sf_q <= 1'b1;
            c1_q <= 1'b0;
        end
    end

    assign exc_vec = {{(EXC_W-1){1'b0}}, ie_q};
    assign es_o    = |(exc_vec & ~mask_i);
    assign ie_o    = ie_q;
    assign sf_o    = sf_q;
    assign c1_o    = c1_q;

    // R5: overflow raises stack fault, invalid and C1
    a_r5_overflow_flags: assert property (@(posedge clk) disable iff (rst)
        fault_i.over |=> (sf_q && ie_q && c1_q));

    // R6: underflow raises stack fault and invalid, clears C1
    a_r6_underflow_flags: assert property (@(posedge clk) disable iff (rst)
        (fault_i.under && !fault_i.over) |=> (sf_q && ie_q && !c1_q));

    // R7: sticky fault flags
    a_r7_sf_sticky: assert property (@(posedge clk) disable iff (rst)
        sf_q |=> sf_q);

    // R7: C1 holds without a fault
    a_r7_c1_hold: assert property (@(posedge clk) disable iff (rst)
        (fault_i == '0) |=> $stable(c1_q));

    // R8: summary never set without an underlying exception
    a_r8_es_needs_ie: assert property (@(posedge clk) disable iff (rst)
        es_o |-> ie_q);

endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
    import fpstk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic [FP_W-1:0]    push_data_i,
    input  logic [EXC_W-1:0]   fpu_mask_i,
    output logic [FP_W-1:0]    tos_data_o,
    output logic [STAT_W-1:0]  status_o,
    output logic [TWORD_W-1:0] tag_word_o
);

    ptr_t               top, idx;
    logic               wr_en, clr_en, wr_nan;
    fault_t             fault;
    logic [TWORD_W-1:0] tag_word;
    fpval_t             wr_data, rd_data, push_val;
    tag_e               wr_tag;
    logic               ie, sf, c1, es;

    assign push_val = fpval_t'(push_data_i);

    fpstk_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .push_i     (push_i),
        .pop_i      (pop_i),
        .tag_word_i (tag_word),
        .top_o      (top),
        .idx_o      (idx),
        .wr_en_o    (wr_en),
        .clr_en_o   (clr_en),
        .wr_nan_o   (wr_nan),
        .fault_o    (fault)
    );

    always_comb begin
        if (wr_nan) begin
            wr_data = QNAN_DEFAULT;
            wr_tag  = TAG_SPECIAL;
        end else begin
            wr_data = push_val;
            wr_tag  = classify_tag(push_val);
        end
    end

    fpstk_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (wr_en),
        .clr_en_i   (clr_en),
        .idx_i      (idx),
        .wr_data_i  (wr_data),
        .wr_tag_i   (wr_tag),
        .rd_idx_i   (top),
        .rd_data_o  (rd_data),
        .tag_word_o (tag_word)
    );

    fpstk_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .fault_i (fault),
        .mask_i  (fpu_mask_i),
        .ie_o    (ie),
        .sf_o    (sf),
        .c1_o    (c1),
        .es_o    (es)
    );

    always_comb begin
        status_o                      = '0;
        status_o[ST_IE]               = ie;
        status_o[ST_SF]               = sf;
        status_o[ST_ES]               = es;
        status_o[ST_C1]               = c1;
        status_o[ST_TOP_LO +: PTR_W]  = top;
    end

    assign tos_data_o = (tag_at(tag_word, top) == TAG_EMPTY) ? QNAN_DEFAULT : rd_data;
    assign tag_word_o = tag_word;

    // R5: an overflowing push leaves a special-tagged register at the new top
    a_r5_overflow_special: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && fault.over) |=> (tag_at(tag_word_o, top) == TAG_SPECIAL));

    // R2: status pointer field follows the pointer after a push
    a_r2_status_field: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i) |=> (status_o[ST_TOP_LO +: PTR_W] == ptr_t'($past(top) - 1'b1)));

endmodule

// File: tb/fpstk_ctrl_bench.sv
`timescale 1ns/1ps
module fpstk_ctrl_bench;

    localparam logic [79:0] NAN_Q = 80'hFFFF_C000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        push_i, pop_i;
    logic [79:0] push_data_i;
    logic [5:0]  mask_i;
    logic [79:0] tos_data_o;
    logic [15:0] status_o, tag_word_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [79:0] m_regs [8];
    logic [1:0]  m_tags [8];
    logic [2:0]  m_top;
    logic        m_sf, m_ie, m_c1;
    string       last_req;

    always #10 clk = ~clk;

    fpstk_ctrl u_fpstk_ctrl (
        .clk         (clk),
        .rst         (rst),
        .push_i      (push_i),
        .pop_i       (pop_i),
        .push_data_i (push_data_i),
        .fpu_mask_i  (mask_i),
        .tos_data_o  (tos_data_o),
        .status_o    (status_o),
        .tag_word_o  (tag_word_o)
    );

    function automatic logic [1:0] ref_tag(input logic [79:0] d);
        logic [14:0] e;
        logic [63:0] s;
        e = d[78:64];
        s = d[63:0];
        if (e == 15'h7FFF)                return 2'b10;
        if (e == 15'h0 && s == 64'h0)     return 2'b01;
        if (e == 15'h0)                   return 2'b10;
        if (s[63] == 1'b0)                return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [15:0] ref_status(input logic [5:0] m);
        logic [15:0] s;
        s        = 16'h0;
        s[0]     = m_ie;
        s[6]     = m_sf;
        s[7]     = m_ie & ~m[0];
        s[9]     = m_c1;
        s[13:11] = m_top;
        return s;
    endfunction

    function automatic logic [15:0] ref_tagword();
        logic [15:0] w;
        for (int i = 0; i < 8; i++) w[2*i +: 2] = m_tags[i];
        return w;
    endfunction

    function automatic logic [79:0] rand_val(input int kind);
        logic [79:0] v;
        logic [14:0] e;
        v = {$urandom, $urandom, $urandom};
        case (kind)
            0: v[78:0] = '0;                                   // zero
            1: v[78:64] = 15'h7FFF;                            // inf / nan
            2: begin v[78:64] = 15'h0; v[0] = 1'b1; end        // denormal
            3: begin                                           // unnormal
                e = v[78:64];
                if (e == 15'h0 || e == 15'h7FFF) e = 15'h1234;
                v[78:64] = e; v[63] = 1'b0;
            end
            default: begin                                     // normal
                e = v[78:64];
                if (e == 15'h0 || e == 15'h7FFF) e = 15'h3FFF;
                v[78:64] = e; v[63] = 1'b1;
            end
        endcase
        return v;
    endfunction

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_edge(input logic p, input logic q, input logic [79:0] d);
        logic [2:0] nt;
        if (p && q) begin
            last_req = "R9";
            if (m_tags[m_top] == 2'b11) begin m_sf = 1; m_ie = 1; m_c1 = 0; end
            m_regs[m_top] = d;
            m_tags[m_top] = ref_tag(d);
        end else if (p) begin
            nt = m_top - 3'd1;
            if (m_tags[nt] != 2'b11) begin
                last_req = "R5";
                m_sf = 1; m_ie = 1; m_c1 = 1;
                m_regs[nt] = NAN_Q;
                m_tags[nt] = 2'b10;
            end else begin
                last_req = "R2";
                m_regs[nt] = d;
                m_tags[nt] = ref_tag(d);
            end
            m_top = nt;
        end else if (q) begin
            if (m_tags[m_top] == 2'b11) begin
                last_req = "R6";
                m_sf = 1; m_ie = 1; m_c1 = 0;
            end else begin
                last_req = "R3";
            end
            m_tags[m_top] = 2'b11;
            m_top = m_top + 3'd1;
        end else begin
            last_req = "R7";
        end
    endtask

    // called at a falling edge
    task automatic step(input logic p, input logic q, input logic [79:0] d, input logic [5:0] m);
        logic [15:0] es;
        push_i = p; pop_i = q; push_data_i = d; mask_i = m;
        #1;
        es = ref_status(m);
        chk(last_req, {64'h0, status_o & 16'hFF7F}, {64'h0, es & 16'hFF7F});
        chk("R8", {79'h0, status_o[7]}, {79'h0, es[7]});
        chk("R4", {64'h0, tag_word_o}, {64'h0, ref_tagword()});
        chk((m_tags[m_top] == 2'b11) ? "R6" : "R3", tos_data_o,
            (m_tags[m_top] == 2'b11) ? NAN_Q : m_regs[m_top]);
        @(posedge clk);
        model_edge(p, q, d);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7717));
        rst = 1'b1; push_i = 0; pop_i = 0; push_data_i = '0; mask_i = 6'h3F;
        for (int i = 0; i < 8; i++) begin m_regs[i] = '0; m_tags[i] = 2'b11; end
        m_top = 0; m_sf = 0; m_ie = 0; m_c1 = 0; last_req = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1", {64'h0, status_o}, 80'h0);
        chk("R1", {64'h0, tag_word_o}, {64'h0, 16'hFFFF});
        chk("R1", tos_data_o, NAN_Q);

        // R2/R4: fill all eight, wrapping 0 -> 7, one of each class
        for (int i = 0; i < 8; i++) step(1, 0, rand_val(i % 5), 6'h3F);
        // R5: ninth push overflows into register 7
        step(1, 0, rand_val(4), 6'h3F);
        // R8: mask bit 0 clear exposes the summary bit
        step(0, 0, '0, 6'h3E);
        step(0, 0, '0, 6'h3F);
        // R3/R6: drain all, then one more pop underflows
        for (int i = 0; i < 9; i++) step(0, 1, '0, 6'h3E);
        // R9: combined request on an empty top, then on a loaded top
        step(1, 1, rand_val(4), 6'h3F);
        step(1, 1, rand_val(0), 6'h3F);
        step(0, 1, '0, 6'h3F);

        // random mix, R9 combined requests included
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 10;
            step(r < 4 || r == 8, (r >= 4 && r < 8) || r == 8,
                 rand_val($urandom % 6), 6'($urandom));
        end
        step(0, 0, '0, 6'h00);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule